// File: doc/BRIEF.md
# Resolver Synchronous Demodulator with Shared Normalizing Window

This block recovers the relative amplitudes of a resolver's two secondary windings so that a later vectoring arctangent stage can turn them into a shaft angle. Each winding has its own pathway. The pathway multiplies the signed ADC sample by the signed excitation reference, which is the same sine wave that drives the primary winding. It then adds the product into a wide running sum. Because the reference is coherent with the carrier on both windings, each sum grows in proportion to that winding's envelope. Noise that is not coherent with the carrier averages away.

A report request freezes both sums and restarts them in the same cycle. The two frozen values are then cut down to 16 bits each. Both cuts use the same bit window, chosen from the data so that redundant sign bits are dropped until one of the two results uses its full signed range. Both values are scaled by the same power of two, so the ratio between them, and therefore the angle, does not depend on how long the sums ran. The result appears with a one-cycle valid strobe, together with a flag that marks an all-zero snapshot.

Top module: `rdc_demod_top`

## Requirements
- R1: While `smp_en` is high, each pathway adds the signed product of its 12-bit sample and the 16-bit signed reference, sign-extended, into its sum. While `smp_en` is low, the sum holds its value.
- R2: In a cycle where `rpt_req` is high, both sums are captured as they stood before that cycle. Each sum then restarts with that cycle's product if `smp_en` is high, or with zero if it is not. No sample is lost and none is counted twice, including when requests come in consecutive cycles.
- R3: The sums are 54 bits wide. A full-scale product (magnitude 2^26) can be accumulated for more than one second at any practical sample rate without wrapping.
- R4: `win_x` and `win_y` are taken from the sine and cosine snapshots with the same right-shift amount s. Each output equals its snapshot arithmetically shifted right by s, kept to 16 bits.
- R5: The shift s is the smallest value in 0..38 for which both shifted snapshots fit in a 16-bit signed range. When s > 0, at least one output has its top two bits differing.
- R6: When both snapshots already fit in 16 signed bits, s is 0 and the outputs are the low 16 bits of the snapshots.
- R7: `win_vld` is high for exactly one cycle, two clock edges after the edge that samples `rpt_req` high. Otherwise it stays low.
- R8: If both snapshots are zero, `win_x` and `win_y` are zero and `win_empty` is high together with `win_vld`. Otherwise `win_empty` is low when `win_vld` is high.
- R9: A synchronous active-high `rst` clears both sums and drives `win_vld`, `win_empty`, `win_x` and `win_y` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe for both channels |
| smp_sin | input | 12 | Signed sample of the sine winding |
| smp_cos | input | 12 | Signed sample of the cosine winding |
| ref_wave | input | 16 | Signed excitation reference |
| rpt_req | input | 1 | Report request strobe |
| win_x | output | 16 | Normalized cosine-channel sum (x) |
| win_y | output | 16 | Normalized sine-channel sum (y) |
| win_vld | output | 1 | One-cycle result strobe |
| win_empty | output | 1 | Both snapshots were zero |

## Verification
Several input patterns are used, and each one separates a different failure. A long run of constant full-scale samples of both signs pushes the shift near its upper end and exposes a wrong window position or a wrong sign extension. A triangle reference with random amplitudes and gaps in `smp_en` tests the multiply, the hold behaviour and the mixed-sign accumulation. Single-sample and no-sample windows test the capped shift and the all-zero flag. Back-to-back requests, including requests that arrive with a sample in the same cycle, show whether a restart drops or double-counts a product.

// File: rtl/rdc_demod_pkg.sv
package rdc_demod_pkg;

    localparam int SMP_W   = 12;
    localparam int REF_W   = 16;
    localparam int ACC_W   = 54;
    localparam int WIN_W   = 16;
    localparam int N_LANES = 2;

    localparam int PROD_W    = SMP_W + REF_W;
    localparam int MAX_SHIFT = ACC_W - WIN_W;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [WIN_W-1:0] win_t;

    // Frozen pair of sums handed to the window stage
    typedef struct packed {
        logic vld;
        acc_t sin_sum;
        acc_t cos_sum;
    } snap_pair_t;

    // Registered window result
    typedef struct packed {
        logic vld;
        logic empty;
        win_t x;
        win_t y;
    } win_res_t;

    // Number of bits just below the MSB that merely repeat the sign
    function automatic int unsigned sign_run(acc_t v);
        int unsigned n;
        logic        going;
        n     = 0;
        going = 1'b1;
        for (int i = ACC_W - 2; i >= 0; i--) begin
            if (going && (v[i] == v[ACC_W-1])) n++;
            else going = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/demod_lane.sv
module demod_lane #(
    parameter int SMP_W = rdc_demod_pkg::SMP_W,
    parameter int REF_W = rdc_demod_pkg::REF_W,
    parameter int ACC_W = rdc_demod_pkg::ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic signed [SMP_W-1:0] smp,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic                    req,
    output logic signed [ACC_W-1:0] snap
);
    localparam int PROD_W = SMP_W + REF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc;

    assign prod     = smp * ref_in;
    assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            snap <= '0;
        end else if (req) begin
            snap <= acc;
            acc  <= smp_en ? prod_ext : '0;
        end else if (smp_en) begin
            acc  <= acc + prod_ext;
        end
    end

    // R1: a sample outside a request cycle adds its product
    assert_accumulate_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(smp_en) && !$past(req) && !$past(rst)) |-> (acc == $past(acc) + $past(prod_ext)));

    // R1: no sample and no request leaves the sum unchanged
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(smp_en) && !$past(req) && !$past(rst)) |-> $stable(acc));

    // R2: the snapshot is the sum as it stood before the request
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(req) && !$past(rst)) |-> (snap == $past(acc)));

endmodule

// File: rtl/norm_window.sv
module norm_window
    import rdc_demod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  snap_pair_t snap_in,
    output win_res_t   res
);
    int unsigned            run_s;
    int unsigned            run_c;
    int unsigned            run_min;
    logic [SHIFT_W-1:0]     sh;
    logic [SHIFT_W-1:0]     sh_q;
    win_t                   cut_x;
    win_t                   cut_y;
    logic                   both_zero;

    always_comb begin
        run_s   = sign_run(snap_in.sin_sum);
        run_c   = sign_run(snap_in.cos_sum);
        run_min = (run_s < run_c) ? run_s : run_c;
        if (run_min >= MAX_SHIFT) sh = '0;
        else                      sh = SHIFT_W'(MAX_SHIFT - int'(run_min));
        cut_x     = snap_in.cos_sum[sh +: WIN_W];
        cut_y     = snap_in.sin_sum[sh +: WIN_W];
        both_zero = (snap_in.sin_sum == '0) && (snap_in.cos_sum == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res  <= '0;
            sh_q <= '0;
        end else begin
            res.vld <= snap_in.vld;
            sh_q    <= sh;
            if (snap_in.vld) begin
                res.x     <= cut_x;
                res.y     <= cut_y;
                res.empty <= both_zero;
            end else begin
                res.empty <= 1'b0;
            end
        end
    end

    // R5: a non-zero shift leaves one output with no redundant sign bit
    assert_full_range_R5: assert property (@(posedge clk) disable iff (rst)
        (res.vld && (sh_q != '0)) |->
            ((res.x[WIN_W-1] ^ res.x[WIN_W-2]) || (res.y[WIN_W-1] ^ res.y[WIN_W-2])));

    // R5: the shift never leaves the sum's range
    assert_shift_range_R5: assert property (@(posedge clk) disable iff (rst)
        res.vld |-> (int'(sh_q) <= MAX_SHIFT));

    // R8: an empty result carries zero data
    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (res.vld && res.empty) |-> ((res.x == '0) && (res.y == '0)));

    // R8: the empty flag never stands alone
    assert_empty_with_vld_R8: assert property (@(posedge clk) disable iff (rst)
        res.empty |-> res.vld);

endmodule

// File: rtl/rdc_demod_top.sv
module rdc_demod_top
    import rdc_demod_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic signed [SMP_W-1:0] smp_sin,
    input  logic signed [SMP_W-1:0] smp_cos,
    input  logic signed [REF_W-1:0] ref_wave,
    input  logic                    rpt_req,
    output logic signed [WIN_W-1:0] win_x,
    output logic signed [WIN_W-1:0] win_y,
    output logic                    win_vld,
    output logic                    win_empty
);
    logic signed [SMP_W-1:0] lane_smp  [N_LANES];
    acc_t                    lane_snap [N_LANES];
    logic                    snap_vld;
    snap_pair_t              pair;
    win_res_t                res;

    // Lane 0 carries the sine winding, lane 1 the cosine winding
    assign lane_smp[0] = smp_sin;
    assign lane_smp[1] = smp_cos;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        demod_lane #(
            .SMP_W (SMP_W),
            .REF_W (REF_W),
            .ACC_W (ACC_W)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .smp_en (smp_en),
            .smp    (lane_smp[g]),
            .ref_in (ref_wave),
            .req    (rpt_req),
            .snap   (lane_snap[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) snap_vld <= 1'b0;
        else     snap_vld <= rpt_req;
    end

    assign pair.vld     = snap_vld;
    assign pair.sin_sum = lane_snap[0];
    assign pair.cos_sum = lane_snap[1];

    norm_window u_win (
        .clk     (clk),
        .rst     (rst),
        .snap_in (pair),
        .res     (res)
    );

    assign win_x     = res.x;
    assign win_y     = res.y;
    assign win_vld   = res.vld;
    assign win_empty = res.empty;

    // R7: the result strobe follows a request by exactly two edges
    assert_vld_latency_R7: assert property (@(posedge clk) disable iff (rst)
        win_vld == ($past(rpt_req, 2) && !$past(rst, 1) && !$past(rst, 2)));

    // R9: the outputs stay quiet in the first cycle out of reset
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!win_vld && !win_empty));

endmodule

// File: tb/sim_rdc_demod_top.sv
`timescale 1ns/1ps
module sim_rdc_demod_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_en = 1'b0;
    logic signed [11:0] smp_sin = '0;
    logic signed [11:0] smp_cos = '0;
    logic signed [15:0] ref_wave = '0;
    logic               rpt_req = 1'b0;
    logic signed [15:0] win_x;
    logic signed [15:0] win_y;
    logic               win_vld;
    logic               win_empty;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    longint m_sin = 0;
    longint m_cos = 0;
    bit     ev [4];
    int     ex [4];
    int     ey [4];
    bit     ee [4];

    always #4 clk = ~clk;

    rdc_demod_top u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .smp_sin   (smp_sin),
        .smp_cos   (smp_cos),
        .ref_wave  (ref_wave),
        .rpt_req   (rpt_req),
        .win_x     (win_x),
        .win_y     (win_y),
        .win_vld   (win_vld),
        .win_empty (win_empty)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Smallest shift at which both values fit 16 signed bits
    task automatic normalize(input longint a, input longint b, output int oa, output int ob);
        for (int s = 0; s <= 38; s++) begin
            longint ta = a >>> s;
            longint tb = b >>> s;
            if (ta >= -32768 && ta <= 32767 && tb >= -32768 && tb <= 32767) begin
                oa = int'(ta);
                ob = int'(tb);
                return;
            end
        end
        oa = 0;
        ob = 0;
    endtask

    task automatic step(input bit en, input int s, input int c, input int r, input bit req);
        int k;
        int slot;
        longint ps;
        longint pc;
        @(negedge clk);
        k = cyc % 4;
        check(win_vld == ev[k], "R7 valid", longint'(win_vld), longint'(ev[k]));
        if (ev[k]) begin
            check(win_x == 16'(ex[k]), "R4/R5 x", longint'(win_x), longint'(ex[k]));
            check(win_y == 16'(ey[k]), "R4/R5 y", longint'(win_y), longint'(ey[k]));
            check(win_empty == ee[k], "R8 empty", longint'(win_empty), longint'(ee[k]));
        end else begin
            check(win_empty == 1'b0, "R8 empty idle", longint'(win_empty), 0);
        end
        ev[k] = 1'b0;

        smp_en   = en;
        smp_sin  = 12'(s);
        smp_cos  = 12'(c);
        ref_wave = 16'(r);
        rpt_req  = req;

        ps = longint'(s) * longint'(r);
        pc = longint'(c) * longint'(r);
        if (req) begin
            int nx;
            int ny;
            slot = (cyc + 2) % 4;
            normalize(m_cos, m_sin, nx, ny);
            ev[slot] = 1'b1;
            ex[slot] = nx;
            ey[slot] = ny;
            ee[slot] = (m_sin == 0) && (m_cos == 0);
            m_sin = en ? ps : 0;
            m_cos = en ? pc : 0;
        end else if (en) begin
            m_sin += ps;
            m_cos += pc;
        end
        cyc++;
    endtask

    function automatic int tri_ref(input int t);
        int p = t % 64;
        if (p < 16)      return p * 2000;
        else if (p < 48) return 64000 - p * 2000;
        else             return p * 2000 - 128000;
    endfunction

    initial begin : watchdog
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 4; i++) ev[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R9: outputs cleared while in reset
        check(win_vld == 0 && win_empty == 0, "R9 reset flags", longint'({win_vld, win_empty}), 0);
        check(win_x == 0 && win_y == 0, "R9 reset data", longint'(win_x), 0);
        rst = 1'b0;

        // R6/R8: request with nothing accumulated (reset cleared the sums, R9)
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        // R6: a single small product stays unshifted
        step(1, 3, -5, 7, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);

        // R1/R5: constant positive DC-like drive, with gaps in smp_en
        for (int i = 0; i < 400; i++) step((i % 3) != 0, 1000, 500, 20000, 0);
        step(0, 0, 0, 0, 1);

        // R1/R4: triangle reference, random amplitudes and mixed signs
        for (int i = 0; i < 600; i++) begin
            int a = int'($urandom_range(0, 4095)) - 2048;
            int b = int'($urandom_range(0, 4095)) - 2048;
            step(($urandom_range(0, 3) != 0), a, b, tri_ref(i), 0);
        end
        step(1, 100, -100, 300, 1);

        // R2/R7: back-to-back requests that each carry a sample
        step(1, -7, 9, 11, 1);
        step(1, 13, -2, -17, 1);
        step(0, 0, 0, 0, 1);
        step(1, 2047, -2048, 32767, 0);
        step(0, 0, 0, 0, 1);

        // R3/R5: long full-scale run of both signs
        for (int i = 0; i < 3000; i++) step(1, -2048, 2047, -32768, 0);
        step(1, -2048, 2047, -32768, 1);
        for (int i = 0; i < 2000; i++) step(1, 2047, -2048, -32768, 0);
        step(0, 0, 0, 0, 1);

        // R8: zero snapshot after a request with no samples
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);

        // R6: negative small values stay unshifted
        step(1, -1, 1, 1, 0);
        step(0, 0, 0, 0, 1);

        // drain the pipeline so every expected result is compared
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule